// File: doc/BRIEF.md
# Burst-Capable Microprocessor Register Interface

This block is a microprocessor bus slave that sits in front of a small bank of configuration and status registers. The host presents an 8-bit address and data bus with an address-latch strobe and separate read and write strobes. The block answers every access through a ready output that is held low for a set number of clock cycles and then raised until the host drops its strobe. All strobes are expected to be synchronous to `clk`.

An access that begins with the latch strobe loads a base address. Later accesses can omit the latch strobe. In that case the block works on an internal address that moves forward by one after each completed access. This lets a host walk through consecutive registers in a burst. Each register follows its own access rule: plain read/write, fixed read-only constant, reserved, clear-on-read status, or a mix of writable control bits and live read-only flags. The status bits are set by one-cycle event inputs. When a status bit is set and its enable bit is also set, the summary interrupt output goes high.

Top module: `mpu_burst_regs`

## Requirements
- R1: A synchronous active-high reset sets the following: every read/write register and the writable bits of address 06h to 00h, every status bit to 0, the internal address to 00h, and `ready_o` and `irq_o` to 0.
- R2: A clock edge with `ale_i` high loads `addr_i` into the internal address. The latch strobe takes priority over the address advance.
- R3: An access completes on the edge where `ready_o` is high and both `rd_i` and `wr_i` are low. At completion the internal address advances by one. After `LAST_ADDR` (08h) it wraps to 00h.
- R4: When a strobe is seen in the idle state, `ready_o` stays low for `WAIT_CYC` clock edges and then goes high. It stays high until the strobe is released. If the strobe is dropped before `ready_o` rises, the access is abandoned and the address does not advance.
- R5: Addresses 00h (mode), 01h (I/O control), 04h (interrupt enable) and 08h (test cell header) read back the last value written. The mode, I/O control and header registers also drive `mode_o`, `ioctl_o` and `tc_hdr_o`.
- R6: Address 02h always reads `PART_ID` and address 03h always reads `VERSION_ID`. Writes to either address are ignored.
- R7: Address 05h is the status register. A high bit on `evt_i` for one cycle sets the matching status bit. A completed read returns the status and then clears exactly the bits that the read returned. An event that arrives in the clearing cycle keeps its bit set.
- R8: Address 06h mixes two kinds of bits. Bits set in `TC_RW_MASK` (default F0h, bits 7:4) are writable and drive `tc_ctrl_o`. The other bits read the live value of `tc_flags_i`, and writes do not affect them.
- R9: Address 07h reads 00h, and a write to it changes no register.
- R10: `irq_o` is high exactly when some status bit and its interrupt enable bit are both set.
- R11: Read data on `rdata_o` is captured on the edge where `ready_o` rises. It stays stable until the next read captures new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address-latch strobe |
| addr_i | input | ADDR_W | Address bus, sampled while `ale_i` is high |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe, held until `ready_o` is seen |
| wr_i | input | 1 | Write strobe, held until `ready_o` is seen |
| rdata_o | output | DATA_W | Captured read data |
| ready_o | output | 1 | Access handshake; high once the wait period ends |
| evt_i | input | DATA_W | One-cycle status event pulses |
| tc_flags_i | input | DATA_W | Live flags shown in the read-only bits of 06h |
| irq_o | output | 1 | Summary interrupt |
| mode_o | output | DATA_W | Operating mode register |
| ioctl_o | output | DATA_W | I/O control register |
| tc_ctrl_o | output | DATA_W | Writable bits of the test cell control register |
| tc_hdr_o | output | DATA_W | Test cell header register |

## Verification
The bench builds the block with `WAIT_CYC = 3`, which differs from the default of 2. This shows that the ready delay follows the parameter and is not a fixed count. The bench also uses `PART_ID = A7h` and `VERSION_ID = 12h`, so the two constants can be told apart from reset values and from each other. It keeps `LAST_ADDR = 8`, which makes the wrap from the header register back to the mode register reachable in a short burst.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2
  } acc_state_t;

  localparam int unsigned A_MODE  = 0;
  localparam int unsigned A_IOCTL = 1;
  localparam int unsigned A_PART  = 2;
  localparam int unsigned A_VER   = 3;
  localparam int unsigned A_IEN   = 4;
  localparam int unsigned A_STAT  = 5;
  localparam int unsigned A_TC    = 6;
  localparam int unsigned A_RSVD  = 7;
  localparam int unsigned A_HDR   = 8;
endpackage

// File: rtl/mbr_access_seq.sv
module mbr_access_seq #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WAIT_CYC  = 2,
  parameter int unsigned LAST_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              wr_commit_o,
  output logic              rd_capture_o,
  output logic              rd_done_o
);
  import mbr_pkg::*;

  localparam int unsigned CNT_W    = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
  localparam int unsigned LAST_CNT = (WAIT_CYC == 0) ? 0 : WAIT_CYC - 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(LAST_ADDR);

  acc_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic              strobe;
  logic              enter_ready;
  logic              done;
  logic [ADDR_W-1:0] next_addr;

  assign strobe    = rd_i | wr_i;
  assign done      = (state == ST_READY) && !strobe;
  assign next_addr = (cur_addr_o == TOP_ADDR) ? '0 : cur_addr_o + 1'b1;

  generate
    if (WAIT_CYC == 0) begin : g_nowait
      assign enter_ready = (state == ST_IDLE) && strobe;
    end else begin : g_wait
      assign enter_ready = (state == ST_WAIT) && strobe && (cnt == CNT_W'(LAST_CNT));
    end
  endgenerate

  assign ready_o      = (state == ST_READY);
  assign wr_commit_o  = enter_ready && wr_i;
  assign rd_capture_o = enter_ready && !wr_i;
  assign rd_done_o    = done && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      is_wr      <= 1'b0;
      cur_addr_o <= '0;
    end else begin
      if (ale_i)     cur_addr_o <= addr_i;
      else if (done) cur_addr_o <= next_addr;

      if (enter_ready) is_wr <= wr_i;

      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (strobe) state <= (WAIT_CYC == 0) ? ST_READY : ST_WAIT;
        end
        ST_WAIT: begin
          if (!strobe)          state <= ST_IDLE;
          else if (enter_ready) state <= ST_READY;
          else                  cnt   <= cnt + 1'b1;
        end
        ST_READY: begin
          if (!strobe) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbr_irq_ctrl.sv
module mbr_irq_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)           stat_o[b] <= 1'b0;
        else if (evt_i[b]) stat_o[b] <= 1'b1;
        else if (clr_i[b]) stat_o[b] <= 1'b0;
      end
    end
  endgenerate

  assign irq_o = |(stat_o & en_i);
endmodule

// File: rtl/mbr_regfile.sv
module mbr_regfile #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PART_ID    = 'h3C,
  parameter int unsigned VERSION_ID = 'h01,
  parameter int unsigned TC_RW_MASK = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_commit_i,
  input  logic              rd_capture_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] tc_flags_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] ioctl_o,
  output logic [DATA_W-1:0] ien_o,
  output logic [DATA_W-1:0] tc_ctrl_o,
  output logic [DATA_W-1:0] tc_hdr_o,
  output logic [DATA_W-1:0] stat_clr_o
);
  import mbr_pkg::*;

  localparam logic [DATA_W-1:0] RW_MASK = DATA_W'(TC_RW_MASK);
  localparam logic [DATA_W-1:0] PART_V  = DATA_W'(PART_ID);
  localparam logic [DATA_W-1:0] VER_V   = DATA_W'(VERSION_ID);
  localparam logic [ADDR_W-1:0] LA_MODE  = ADDR_W'(A_MODE);
  localparam logic [ADDR_W-1:0] LA_IOCTL = ADDR_W'(A_IOCTL);
  localparam logic [ADDR_W-1:0] LA_PART  = ADDR_W'(A_PART);
  localparam logic [ADDR_W-1:0] LA_VER   = ADDR_W'(A_VER);
  localparam logic [ADDR_W-1:0] LA_IEN   = ADDR_W'(A_IEN);
  localparam logic [ADDR_W-1:0] LA_STAT  = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] LA_TC    = ADDR_W'(A_TC);
  localparam logic [ADDR_W-1:0] LA_HDR   = ADDR_W'(A_HDR);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr_i)
      LA_MODE:  rd_mux = mode_o;
      LA_IOCTL: rd_mux = ioctl_o;
      LA_PART:  rd_mux = PART_V;
      LA_VER:   rd_mux = VER_V;
      LA_IEN:   rd_mux = ien_o;
      LA_STAT:  rd_mux = stat_i;
      LA_TC:    rd_mux = tc_ctrl_o | (tc_flags_i & ~RW_MASK);
      LA_HDR:   rd_mux = tc_hdr_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= '0;
      ioctl_o   <= '0;
      ien_o     <= '0;
      tc_ctrl_o <= '0;
      tc_hdr_o  <= '0;
      rdata_o   <= '0;
    end else begin
      if (wr_commit_i) begin
        case (addr_i)
          LA_MODE:  mode_o    <= wdata_i;
          LA_IOCTL: ioctl_o   <= wdata_i;
          LA_IEN:   ien_o     <= wdata_i;
          LA_TC:    tc_ctrl_o <= wdata_i & RW_MASK;
          LA_HDR:   tc_hdr_o  <= wdata_i;
          default:  ;
        endcase
      end
      if (rd_capture_i) rdata_o <= rd_mux;
    end
  end

  assign stat_clr_o = (rd_done_i && addr_i == LA_STAT) ? rdata_o : '0;
endmodule

// File: rtl/mpu_burst_regs.sv
module mpu_burst_regs #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LAST_ADDR  = 8,
  parameter int unsigned WAIT_CYC   = 2,
  parameter int unsigned PART_ID    = 'h3C,
  parameter int unsigned VERSION_ID = 'h01,
  parameter int unsigned TC_RW_MASK = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] tc_flags_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] ioctl_o,
  output logic [DATA_W-1:0] tc_ctrl_o,
  output logic [DATA_W-1:0] tc_hdr_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_commit;
  logic              rd_capture;
  logic              rd_done;
  logic [DATA_W-1:0] irq_en;
  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] stat_clr;

  mbr_access_seq #(
    .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .LAST_ADDR(LAST_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .ale_i(ale_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .ready_o(ready_o), .cur_addr_o(cur_addr),
    .wr_commit_o(wr_commit), .rd_capture_o(rd_capture), .rd_done_o(rd_done)
  );

  mbr_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PART_ID(PART_ID),
    .VERSION_ID(VERSION_ID), .TC_RW_MASK(TC_RW_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .addr_i(cur_addr), .wdata_i(wdata_i),
    .wr_commit_i(wr_commit), .rd_capture_i(rd_capture), .rd_done_i(rd_done),
    .stat_i(stat), .tc_flags_i(tc_flags_i), .rdata_o(rdata_o),
    .mode_o(mode_o), .ioctl_o(ioctl_o), .ien_o(irq_en),
    .tc_ctrl_o(tc_ctrl_o), .tc_hdr_o(tc_hdr_o), .stat_clr_o(stat_clr)
  );

  mbr_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .evt_i(evt_i), .en_i(irq_en),
    .clr_i(stat_clr), .stat_o(stat), .irq_o(irq_o)
  );
endmodule

// File: rtl/mbr_regs_chk.sv
module mbr_regs_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LAST_ADDR = 8,
  parameter int unsigned WAIT_CYC  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ale_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] evt_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [DATA_W-1:0] irq_en
);
  localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(LAST_ADDR);
  localparam logic [ADDR_W-1:0] RSVD_A = ADDR_W'(7);

  logic [15:0] held;
  always_ff @(posedge clk) begin
    if (rst || !(rd_i || wr_i)) held <= '0;
    else if (!ready_o && held != 16'hFFFF) held <= held + 1'b1;
  end

  // R2
  a_r2_latch: assert property (@(posedge clk) disable iff (rst)
    ale_i |=> cur_addr == $past(addr_i));

  // R3
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !rd_i && !wr_i && !ale_i) |=>
      cur_addr == (($past(cur_addr) == TOP_A) ? '0 : $past(cur_addr) + 1'b1));

  // R4
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    !(rd_i || wr_i) |=> !ready_o);

  // R4
  a_r4_wait_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> held >= 16'(WAIT_CYC));

  // R9
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (ready_o && rd_i && !wr_i && cur_addr == RSVD_A && !ale_i && $stable(cur_addr)) |->
      rdata_o == '0);

  // R10
  a_r10_irq_event: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & irq_en) != '0) |=> (irq_o || ((irq_en & $past(evt_i)) == '0)));
endmodule

bind mpu_burst_regs mbr_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .WAIT_CYC(WAIT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ale_i(ale_i), .addr_i(addr_i), .rd_i(rd_i),
  .wr_i(wr_i), .ready_o(ready_o), .rdata_o(rdata_o), .evt_i(evt_i),
  .irq_o(irq_o), .cur_addr(cur_addr), .irq_en(irq_en)
);

// File: tb/mpu_burst_regs_tb.sv
`timescale 1ns/1ps
module mpu_burst_regs_tb;
  localparam int WAITS = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] rdata_o;
  logic       ready_o;
  logic [7:0] evt_i = '0;
  logic [7:0] tc_flags_i = 8'h0A;
  logic       irq_o;
  logic [7:0] mode_o, ioctl_o, tc_ctrl_o, tc_hdr_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mpu_burst_regs #(
    .WAIT_CYC(WAITS), .PART_ID('hA7), .VERSION_ID('h12)
  ) u_dut (
    .clk(clk), .rst(rst), .ale_i(ale_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .wr_i(wr_i), .rdata_o(rdata_o), .ready_o(ready_o),
    .evt_i(evt_i), .tc_flags_i(tc_flags_i), .irq_o(irq_o), .mode_o(mode_o),
    .ioctl_o(ioctl_o), .tc_ctrl_o(tc_ctrl_o), .tc_hdr_o(tc_hdr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] a);
    ale_i = 1'b1; addr_i = a;
    @(negedge clk);
    ale_i = 1'b0;
  endtask

  task automatic acc(input bit w, input logic [7:0] d,
                     output logic [7:0] q, output int waits);
    waits = 0;
    wr_i = w; rd_i = !w; wdata_i = d;
    while (!ready_o && waits < 50) begin
      @(negedge clk);
      waits++;
    end
    q = rdata_o;
    rd_i = 1'b0; wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] q; int w;
    acc(1'b1, d, q, w);
  endtask

  task automatic rd(output logic [7:0] q);
    int w;
    acc(1'b0, 8'h00, q, w);
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] q;
    chk("R1 ready", ready_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 tc_ctrl", tc_ctrl_o, 0);
    rd(q); chk("R1 addr0 read", q, 0);
    rd(q); chk("R1 addr1 read", q, 0);
    rd(q); chk("R1 counter starts at 0 (reach 02h)", q, 'hA7);
  endtask

  task automatic t_timing;
    logic [7:0] q; int w;
    latch(8'h03);
    acc(1'b0, 8'h00, q, w);
    chk("R4 wait cycles", w, WAITS + 1);
    chk("R11 capture", q, 'h12);
    repeat (3) @(negedge clk);
    chk("R11 held after access", rdata_o, 'h12);
    latch(8'h02);
    rd_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 ready low early", ready_o, 0);
    rd_i = 1'b0;
    @(negedge clk);
    rd(q); chk("R4 abort keeps address", q, 'hA7);
  endtask

  task automatic t_rw_burst;
    logic [7:0] q;
    latch(8'h00);
    wr(8'h11); wr(8'h22);
    chk("R5 mode_o", mode_o, 'h11);
    chk("R5 ioctl_o", ioctl_o, 'h22);
    latch(8'h08);
    wr(8'h88);
    chk("R5 hdr_o", tc_hdr_o, 'h88);
    rd(q); chk("R3 wrap to 00h", q, 'h11);
    rd(q); chk("R3 burst to 01h", q, 'h22);
    latch(8'h00);
    rd(q); chk("R2 latch 00h", q, 'h11);
    latch(8'h08);
    rd(q); chk("R5 read 08h", q, 'h88);
  endtask

  task automatic t_const;
    logic [7:0] q;
    latch(8'h02);
    wr(8'hFF); wr(8'hFF);
    latch(8'h02);
    rd(q); chk("R6 part", q, 'hA7);
    rd(q); chk("R6 version", q, 'h12);
  endtask

  task automatic t_mixed_rsvd;
    logic [7:0] q;
    latch(8'h06);
    wr(8'hFF); wr(8'hFF);
    chk("R8 ctrl bits", tc_ctrl_o, 'hF0);
    latch(8'h06);
    rd(q); chk("R8 mixed read", q, 'hFA);
    rd(q); chk("R9 reserved reads zero", q, 0);
    rd(q); chk("R9 write left 08h", q, 'h88);
    latch(8'h06);
    wr(8'h35);
    tc_flags_i = 8'h05;
    latch(8'h06);
    rd(q); chk("R8 live flags", q, 'h35);
  endtask

  task automatic t_status;
    logic [7:0] q;
    pulse(8'h02);
    chk("R10 masked irq", irq_o, 0);
    latch(8'h05);
    rd(q); chk("R7 status set", q, 'h02);
    latch(8'h05);
    rd(q); chk("R7 cleared on read", q, 0);
    latch(8'h04);
    wr(8'h02);
    latch(8'h04);
    rd(q); chk("R5 enable readback", q, 'h02);
    pulse(8'h01);
    chk("R10 other bit not enabled", irq_o, 0);
    pulse(8'h02);
    chk("R10 irq on enabled bit", irq_o, 1);
    latch(8'h05);
    rd(q); chk("R7 both bits", q, 'h03);
    chk("R10 irq after clear", irq_o, 0);
    pulse(8'h04);
    latch(8'h05);
    rd_i = 1'b1;
    while (!ready_o) @(negedge clk);
    evt_i = 8'h04;
    rd_i = 1'b0;
    @(negedge clk);
    evt_i = '0;
    latch(8'h05);
    rd(q); chk("R7 event in clear cycle kept", q, 'h04);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_rw_burst();
    t_const();
    t_mixed_rsvd();
    t_status();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule